// File: doc/BRIEF.md
# Non-Blocking Far-Memory Request Tracker

This block lets a processor core start transfers between a slow, far memory and a local scratchpad without waiting for them. A read (far memory into scratchpad) or a write (scratchpad out to far memory) is accepted in a single handshake. In that same cycle the block hands back a tag, so the issuing instruction can retire at once. The accepted request waits in an ordered queue toward memory. For a write, the outgoing data is taken from the scratchpad at issue time.

The memory side may answer in any order. Each answer carries the tag of the request it belongs to. When the answer is to a read, the block writes the returned data into the scratchpad location that the request named. Finished requests stay marked in a per-tag table until software polls. Each poll reports one finished tag, always the lowest-numbered one, and that poll returns the tag to the free pool. The tag space covers 128 entries by default, which is enough to keep on the order of a hundred-plus transfers outstanding.

Top module: `farmem_async_tracker`

## Requirements
- R1: While `iss_ready` is high, `iss_id` shows the lowest-numbered free tag. A request is accepted on a clock edge where `iss_valid` and `iss_ready` are both high, and it takes the tag shown in that cycle. After reset the first tag handed out is 0.
- R2: Accepted requests reach the memory request port in issue order. Each one carries its kind (`mreq_write` = 1 for a write, 0 for a read), its far address, its scratchpad address and its tag.
- R3: For a write, `mreq_wdata` equals the scratchpad data present at the issue handshake. Scratchpad changes made after issue have no effect on it.
- R4: A response for a pending read produces `spm_wr_en` = 1 in the same cycle, with `spm_wr_addr` set to the scratchpad address recorded at issue and `spm_wr_data` = `mrsp_data`. A response for a pending write produces no scratchpad write. Responses may arrive in any tag order.
- R5: When no request has finished and not yet been polled, `poll_hit` is 0.
- R6: When several tags have finished, `poll_id` shows the lowest-numbered finished tag. A poll that hits moves on to the next one.
- R7: A tag becomes free only on the clock edge of a poll that reports it, and only then can it be handed out again. A finished tag stays reported until it is polled.
- R8: `iss_ready` is 0 when all tags are in use or when the request queue is full. While it is 0, `iss_valid` has no effect: no tag is taken and nothing is queued.
- R9: Reset (asynchronous, active low) empties the request queue, clears every finished mark and frees every tag.
- R10: While `mreq_valid` is 1 and `mreq_ready` is 0, the memory request outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Core presents a read or write request |
| iss_write | input | 1 | 1 = write (scratchpad to far memory), 0 = read |
| iss_far_addr | input | AW | Far-memory address |
| iss_spm_addr | input | SW | Scratchpad address (destination or source) |
| iss_ready | output | 1 | Request can be accepted this cycle |
| iss_id | output | IW | Tag assigned to the request accepted this cycle |
| spm_rd_addr | output | SW | Scratchpad read address (write-data capture) |
| spm_rd_data | input | DW | Scratchpad read data |
| mreq_valid | output | 1 | Memory request available |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_write | output | 1 | Request kind, 1 = write |
| mreq_far_addr | output | AW | Far-memory address |
| mreq_spm_addr | output | SW | Scratchpad address of the request |
| mreq_wdata | output | DW | Captured write data |
| mreq_id | output | IW | Request tag |
| mrsp_valid | input | 1 | Memory response strobe |
| mrsp_id | input | IW | Tag of the finished request |
| mrsp_data | input | DW | Read data for read responses |
| spm_wr_en | output | 1 | Scratchpad write strobe |
| spm_wr_addr | output | SW | Scratchpad write address |
| spm_wr_data | output | DW | Scratchpad write data |
| poll_req | input | 1 | Completion poll; frees the reported tag |
| poll_hit | output | 1 | A finished tag is available |
| poll_id | output | IW | Lowest finished tag |

## Verification
Some properties are checked on every cycle. The checker keeps its own count of tags in use and uses it to show that issue is refused when the tag space is exhausted and that no poll hits while nothing is live. It also shows that a tag handed out is never the one being reported as finished, that a finished mark persists until polled, and that a stalled memory request holds steady. Other behaviour is only shown by the bench's scenarios: the lowest-first selection of tags and polls, tag reuse after a poll, the capture of write data against later scratchpad changes, read data landing at the recorded scratchpad address for responses out of order, queue-full refusal, and the state left by a reset in mid-run.

// File: rtl/trk_pkg.sv
`timescale 1ns/1ps
package trk_pkg;
  // Per-tag lifecycle: handed out -> waiting on memory -> finished -> polled back to free
  typedef enum logic [1:0] {
    SLOT_FREE = 2'b00,
    SLOT_PEND = 2'b01,
    SLOT_DONE = 2'b10
  } slot_state_e;
endpackage

// File: rtl/trk_id_table.sv
`timescale 1ns/1ps
module trk_id_table
  import trk_pkg::*;
#(
  parameter int NUM_IDS = 128,
  parameter int SW      = 10,
  parameter int IW      = $clog2(NUM_IDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic          alloc_is_read,
  input  logic [SW-1:0] alloc_spm,
  input  logic          done_en,
  input  logic [IW-1:0] done_id,
  input  logic          rel_en,
  output logic          any_free,
  output logic [IW-1:0] free_id,
  output logic          any_done,
  output logic [IW-1:0] done_lo_id,
  output logic          rsp_pend,
  output logic          rsp_is_read,
  output logic [SW-1:0] rsp_spm
);

  slot_state_e   st_q  [NUM_IDS];
  logic          rd_q  [NUM_IDS];
  logic [SW-1:0] spm_q [NUM_IDS];

  // lowest-index search for a free tag and for a finished tag
  always_comb begin
    any_free   = 1'b0;
    free_id    = '0;
    any_done   = 1'b0;
    done_lo_id = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (st_q[i] == SLOT_FREE) begin
        any_free = 1'b1;
        free_id  = IW'(i);
      end
      if (st_q[i] == SLOT_DONE) begin
        any_done   = 1'b1;
        done_lo_id = IW'(i);
      end
    end
  end

  // lookup for the incoming memory response
  always_comb begin
    rsp_pend    = (st_q[done_id] == SLOT_PEND);
    rsp_is_read = rd_q[done_id];
    rsp_spm     = spm_q[done_id];
  end

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_slot
    logic        hit_alloc;
    logic        hit_done;
    logic        hit_rel;
    logic        st_en;
    slot_state_e st_d;

    always_comb begin
      hit_alloc = alloc_en && any_free && (free_id == IW'(g));
      hit_done  = done_en && (done_id == IW'(g)) && (st_q[g] == SLOT_PEND);
      hit_rel   = rel_en && any_done && (done_lo_id == IW'(g));
      st_en     = hit_alloc | hit_done | hit_rel;
      st_d      = st_q[g];
      if (hit_alloc)      st_d = SLOT_PEND;
      else if (hit_done)  st_d = SLOT_DONE;
      else if (hit_rel)   st_d = SLOT_FREE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q[g] <= SLOT_FREE;
      else if (st_en) st_q[g] <= st_d;
    end

    always_ff @(posedge clk) begin
      if (hit_alloc) begin
        rd_q[g]  <= alloc_is_read;
        spm_q[g] <= alloc_spm;
      end
    end
  end

endmodule

// File: rtl/trk_req_fifo.sv
`timescale 1ns/1ps
module trk_req_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         full,
  output logic         empty,
  output logic [W-1:0] head
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok, ptr_en;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign head  = mem[rd_q];

  always_comb begin
    push_ok = push && !full;
    pop_ok  = pop && !empty;
    ptr_en  = push_ok || pop_ok;
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (push_ok) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop_ok)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (ptr_en) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= push_data;
  end

endmodule

// File: rtl/farmem_async_tracker.sv
`timescale 1ns/1ps
module farmem_async_tracker #(
  parameter int NUM_IDS = 128,
  parameter int QDEPTH  = 16,
  parameter int AW      = 32,
  parameter int SW      = 10,
  parameter int DW      = 64,
  parameter int IW      = $clog2(NUM_IDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic          iss_write,
  input  logic [AW-1:0] iss_far_addr,
  input  logic [SW-1:0] iss_spm_addr,
  output logic          iss_ready,
  output logic [IW-1:0] iss_id,
  output logic [SW-1:0] spm_rd_addr,
  input  logic [DW-1:0] spm_rd_data,
  output logic          mreq_valid,
  input  logic          mreq_ready,
  output logic          mreq_write,
  output logic [AW-1:0] mreq_far_addr,
  output logic [SW-1:0] mreq_spm_addr,
  output logic [DW-1:0] mreq_wdata,
  output logic [IW-1:0] mreq_id,
  input  logic          mrsp_valid,
  input  logic [IW-1:0] mrsp_id,
  input  logic [DW-1:0] mrsp_data,
  output logic          spm_wr_en,
  output logic [SW-1:0] spm_wr_addr,
  output logic [DW-1:0] spm_wr_data,
  input  logic          poll_req,
  output logic          poll_hit,
  output logic [IW-1:0] poll_id
);

  localparam int EW = 1 + AW + SW + DW + IW;

  logic          any_free, q_full, q_empty, accept;
  logic          rsp_pend, rsp_is_read;
  logic [SW-1:0] rsp_spm;
  logic [EW-1:0] q_in, q_head;

  // issue side: a tag and a queue slot are both needed
  assign iss_ready   = any_free && !q_full;
  assign accept      = iss_valid && iss_ready;
  assign spm_rd_addr = iss_spm_addr;
  assign q_in        = {iss_write, iss_far_addr, iss_spm_addr, spm_rd_data, iss_id};

  trk_id_table #(
    .NUM_IDS (NUM_IDS),
    .SW      (SW),
    .IW      (IW)
  ) u_tags (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_en      (accept),
    .alloc_is_read (!iss_write),
    .alloc_spm     (iss_spm_addr),
    .done_en       (mrsp_valid),
    .done_id       (mrsp_id),
    .rel_en        (poll_req),
    .any_free      (any_free),
    .free_id       (iss_id),
    .any_done      (poll_hit),
    .done_lo_id    (poll_id),
    .rsp_pend      (rsp_pend),
    .rsp_is_read   (rsp_is_read),
    .rsp_spm       (rsp_spm)
  );

  trk_req_fifo #(
    .DEPTH (QDEPTH),
    .W     (EW)
  ) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_data (q_in),
    .pop       (mreq_ready),
    .full      (q_full),
    .empty     (q_empty),
    .head      (q_head)
  );

  assign mreq_valid = !q_empty;
  assign {mreq_write, mreq_far_addr, mreq_spm_addr, mreq_wdata, mreq_id} = q_head;

  // response side: read data lands at the scratchpad address kept per tag
  assign spm_wr_en   = mrsp_valid && rsp_pend && rsp_is_read;
  assign spm_wr_addr = rsp_spm;
  assign spm_wr_data = mrsp_data;

endmodule

// File: rtl/trk_checker.sv
`timescale 1ns/1ps
module trk_checker #(
  parameter int NUM_IDS = 128,
  parameter int AW      = 32,
  parameter int SW      = 10,
  parameter int DW      = 64,
  parameter int IW      = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iss_valid,
  input logic          iss_ready,
  input logic [IW-1:0] iss_id,
  input logic          mreq_valid,
  input logic          mreq_ready,
  input logic          mreq_write,
  input logic [AW-1:0] mreq_far_addr,
  input logic [SW-1:0] mreq_spm_addr,
  input logic [DW-1:0] mreq_wdata,
  input logic [IW-1:0] mreq_id,
  input logic          poll_req,
  input logic          poll_hit,
  input logic [IW-1:0] poll_id
);

  localparam int LW = $clog2(NUM_IDS + 1);

  logic [LW-1:0] live_q;
  logic          acc, rel;

  assign acc = iss_valid && iss_ready;
  assign rel = poll_req && poll_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           live_q <= '0;
    else if (acc && !rel) live_q <= live_q + 1'b1;
    else if (rel && !acc) live_q <= live_q - 1'b1;
  end

  // R8: no tag left means no acceptance
  a_r8_refuse_when_exhausted: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q == LW'(NUM_IDS)) |-> !iss_ready);

  // R5: nothing live, nothing to report
  a_r5_no_hit_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q == '0) |-> !poll_hit);

  // R7: the tag being handed out is never the finished one on offer
  a_r7_no_reuse_of_done: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && poll_hit) |-> (iss_id != poll_id));

  // R7: a finished tag stays reported until polled
  a_r7_done_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_hit && !poll_req) |=> (poll_hit && poll_id <= $past(poll_id)));

  // R2: an accepted request reaches the memory port
  a_r2_queue_fills: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> mreq_valid);

  // R10: stalled memory request is held
  a_r10_mreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> (mreq_valid &&
      $stable({mreq_write, mreq_far_addr, mreq_spm_addr, mreq_wdata, mreq_id})));

endmodule

bind farmem_async_tracker trk_checker #(
  .NUM_IDS (NUM_IDS),
  .AW      (AW),
  .SW      (SW),
  .DW      (DW),
  .IW      (IW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .iss_valid     (iss_valid),
  .iss_ready     (iss_ready),
  .iss_id        (iss_id),
  .mreq_valid    (mreq_valid),
  .mreq_ready    (mreq_ready),
  .mreq_write    (mreq_write),
  .mreq_far_addr (mreq_far_addr),
  .mreq_spm_addr (mreq_spm_addr),
  .mreq_wdata    (mreq_wdata),
  .mreq_id       (mreq_id),
  .poll_req      (poll_req),
  .poll_hit      (poll_hit),
  .poll_id       (poll_id)
);

// File: tb/farmem_async_tracker_tb.sv
`timescale 1ns/1ps
module farmem_async_tracker_tb;
  localparam int NUM = 128;
  localparam int QD  = 8;
  localparam int AW  = 16;
  localparam int SW  = 6;
  localparam int DW  = 16;
  localparam int IW  = 7;
  localparam realtime TCK = 8ns;

  typedef struct {
    bit            wr;
    logic [AW-1:0] far;
    logic [SW-1:0] sa;
    logic [DW-1:0] data;
    int            id;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic iss_valid, iss_write, iss_ready;
  logic [AW-1:0] iss_far_addr;
  logic [SW-1:0] iss_spm_addr, spm_rd_addr, mreq_spm_addr, spm_wr_addr;
  logic [IW-1:0] iss_id, mreq_id, mrsp_id, poll_id;
  logic [DW-1:0] spm_rd_data, mreq_wdata, mrsp_data, spm_wr_data;
  logic mreq_valid, mreq_ready, mreq_write, mrsp_valid, spm_wr_en, poll_req, poll_hit;
  logic [AW-1:0] mreq_far_addr;

  logic [DW-1:0] spm [2**SW];
  logic          poke_en;
  logic [SW-1:0] poke_addr;
  logic [DW-1:0] poke_data;

  int    n_checks = 0;
  int    n_fail   = 0;
  item_t sb[$];
  int    mst [NUM];
  bit    mrd [NUM];
  int    mspm [NUM];

  always #(TCK/2) clk = ~clk;

  farmem_async_tracker #(
    .NUM_IDS(NUM), .QDEPTH(QD), .AW(AW), .SW(SW), .DW(DW), .IW(IW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_write(iss_write), .iss_far_addr(iss_far_addr),
    .iss_spm_addr(iss_spm_addr), .iss_ready(iss_ready), .iss_id(iss_id),
    .spm_rd_addr(spm_rd_addr), .spm_rd_data(spm_rd_data),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_write(mreq_write),
    .mreq_far_addr(mreq_far_addr), .mreq_spm_addr(mreq_spm_addr),
    .mreq_wdata(mreq_wdata), .mreq_id(mreq_id),
    .mrsp_valid(mrsp_valid), .mrsp_id(mrsp_id), .mrsp_data(mrsp_data),
    .spm_wr_en(spm_wr_en), .spm_wr_addr(spm_wr_addr), .spm_wr_data(spm_wr_data),
    .poll_req(poll_req), .poll_hit(poll_hit), .poll_id(poll_id)
  );

  // scratchpad model
  assign spm_rd_data = spm[spm_rd_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2**SW; i++) spm[i] <= DW'(i * 257);
    end else begin
      if (poke_en)   spm[poke_addr]   <= poke_data;
      if (spm_wr_en) spm[spm_wr_addr] <= spm_wr_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lowest(input int s);
    for (int i = 0; i < NUM; i++) if (mst[i] == s) return i;
    return -1;
  endfunction

  // monitor: pop expected items on each memory handshake
  always begin
    item_t it;
    @(negedge clk);
    #3;
    if (rst_n === 1'b1 && mreq_valid === 1'b1 && mreq_ready === 1'b1) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2 unexpected request", 32'(mreq_id), 32'hFFFF);
      end else begin
        it = sb.pop_front();
        chk(mreq_id == IW'(it.id), "R2 tag order", 32'(mreq_id), 32'(it.id));
        chk(mreq_write == it.wr && mreq_far_addr == it.far && mreq_spm_addr == it.sa,
            "R2 fields", {15'd0, mreq_write, mreq_far_addr}, {15'd0, it.wr, it.far});
        if (it.wr) chk(mreq_wdata == it.data, "R3 write data", 32'(mreq_wdata), 32'(it.data));
      end
    end
  end

  task automatic do_issue(input bit wr, input logic [AW-1:0] far, input logic [SW-1:0] sa);
    item_t it;
    int    e;
    @(negedge clk);
    iss_valid = 1'b1; iss_write = wr; iss_far_addr = far; iss_spm_addr = sa;
    #1;
    e = lowest(0);
    chk(iss_ready === 1'b1, "R8 ready with free tag", 32'(iss_ready), 32'd1);
    chk(iss_id === IW'(e), "R1 lowest free tag", 32'(iss_id), 32'(e));
    it.wr = wr; it.far = far; it.sa = sa; it.data = spm[sa]; it.id = e;
    sb.push_back(it);
    mst[e] = 1; mrd[e] = !wr; mspm[e] = int'(sa);
    @(posedge clk);
    #1 iss_valid = 1'b0;
  endtask

  task automatic do_rsp(input int id, input logic [DW-1:0] d);
    @(negedge clk);
    mrsp_valid = 1'b1; mrsp_id = IW'(id); mrsp_data = d;
    #1;
    chk(spm_wr_en === mrd[id], "R4 scratchpad strobe", 32'(spm_wr_en), 32'(mrd[id]));
    if (mrd[id]) chk(spm_wr_addr === SW'(mspm[id]), "R4 scratchpad addr", 32'(spm_wr_addr), 32'(mspm[id]));
    @(posedge clk);
    #1 mrsp_valid = 1'b0;
    mst[id] = 2;
    if (mrd[id]) chk(spm[mspm[id]] === d, "R4 data landed", 32'(spm[mspm[id]]), 32'(d));
  endtask

  task automatic do_poll();
    int e;
    @(negedge clk);
    poll_req = 1'b1;
    #1;
    e = lowest(2);
    chk(poll_hit === (e >= 0), "R5 poll hit flag", 32'(poll_hit), 32'(e >= 0));
    if (e >= 0) chk(poll_id === IW'(e), "R6 lowest finished tag", 32'(poll_id), 32'(e));
    @(posedge clk);
    #1 poll_req = 1'b0;
    if (e >= 0) mst[e] = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NUM; i++) mst[i] = 0;
    #1;
    chk(iss_ready === 1'b1 && iss_id === '0, "R9 tags free after reset", 32'(iss_id), 32'd0);
    chk(mreq_valid === 1'b0, "R9 queue empty after reset", 32'(mreq_valid), 32'd0);
    chk(poll_hit === 1'b0, "R9 no finished after reset", 32'(poll_hit), 32'd0);
  endtask

  initial begin
    #(TCK * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    iss_valid = 0; iss_write = 0; iss_far_addr = '0; iss_spm_addr = '0;
    mreq_ready = 0; mrsp_valid = 0; mrsp_id = '0; mrsp_data = '0; poll_req = 0;
    poke_en = 0; poke_addr = '0; poke_data = '0;
    do_reset();

    // R1 R2 R3: read then write, scratchpad changed while the write waits
    do_issue(1'b0, 16'h0100, 6'd3);
    do_issue(1'b1, 16'h0200, 6'd5);
    @(negedge clk);
    poke_en = 1; poke_addr = 6'd5; poke_data = 16'h1111;
    @(negedge clk);
    poke_en = 0;
    chk(mreq_valid === 1'b1, "R10 request held while stalled", 32'(mreq_valid), 32'd1);
    mreq_ready = 1;
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R2 all requests seen", sb.size(), 0);

    // R5 R4 R6 R7: out-of-order responses, polling order, tag reuse
    do_poll();
    do_rsp(1, 16'h0);
    do_rsp(0, 16'h5A5A);
    do_issue(1'b0, 16'h0300, 6'd7);   // R7: tags 0,1 finished but not free -> 2
    do_poll();
    do_poll();
    do_issue(1'b1, 16'h0400, 6'd9);   // R7: tag 0 reused
    do_rsp(2, 16'hC3C3);
    do_rsp(0, 16'h0);
    do_poll();
    do_poll();
    do_poll();

    // R8: queue full refuses issue
    repeat (3) @(negedge clk);
    mreq_ready = 0;
    for (int k = 0; k < QD; k++) do_issue(k[0], AW'(16'h1000 + k), SW'(k + 10));
    @(negedge clk);
    iss_valid = 1; iss_write = 1; iss_far_addr = 16'hDEAD; iss_spm_addr = 6'd1;
    #1 chk(iss_ready === 1'b0, "R8 queue full", 32'(iss_ready), 32'd0);
    repeat (2) @(negedge clk);
    iss_valid = 0;
    mreq_ready = 1;
    repeat (QD + 2) @(negedge clk);
    chk(sb.size() == 0 && mreq_valid === 1'b0, "R8 refused issue not queued", sb.size(), 0);

    // R8: tag space exhausted
    while (lowest(0) >= 0) do_issue(1'b0, 16'h2000, 6'd20);
    @(negedge clk);
    #1 chk(iss_ready === 1'b0, "R8 all tags in use", 32'(iss_ready), 32'd0);
    do_poll();
    do_rsp(77, 16'h7777);
    do_poll();
    do_issue(1'b1, 16'h3000, 6'd2);
    chk(sb.size() <= 1, "R7 freed tag reissued", sb.size(), 1);
    repeat (4) @(negedge clk);
    #1 chk(iss_ready === 1'b0, "R8 exhausted again", 32'(iss_ready), 32'd0);

    // R9: reset mid-run with live tags
    do_reset();
    do_issue(1'b0, 16'h4000, 6'd4);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule